// File: doc/BRIEF.md
# Trap Entry State Update Unit

This block computes the architectural state that a 32-bit processor core writes when it takes a trap. A trap request arrives as a one-cycle pulse carrying an interrupt/exception flag, a raw cause code and a faulting address. Alongside it the core presents the current pc, the current privilege level, the supervisor and machine interrupt-enable bits, the two delegation masks and the two trap-vector registers. One clock edge later the block presents a complete update record. The record holds the chosen target level, the new privilege, the cause word, the saved pc, the trap value, the saved enable and previous-privilege fields, and the new fetch address. The core commits this record into its own registers.

The block also owns the load-reservation flag used by load-reserved/store-conditional pairs. A reservation is set by a pulse from the core. It is dropped whenever the privilege level changes, whether the change comes from a trap taken here or from anything else that alters the privilege input.

Privilege is encoded U=0, S=1, M=3. The value 2 is reserved and is treated like machine mode.

Top module: `trap_entry_unit`

## Requirements
- R1: The delegation mask is `deleg_int` for interrupts and `deleg_exc` for exceptions, indexed by the final cause code. The trap targets supervisor (`upd_to_s`=1, `upd_priv`=1) only when the current privilege is 0 or 1 and the indexed mask bit is 1. Otherwise it targets machine (`upd_to_s`=0, `upd_priv`=3).
- R2: `upd_pie` carries the old enable bit of the target level (`cur_sie` for supervisor, `cur_mie` for machine). For a machine trap, `upd_pp` carries the current privilege. For a supervisor trap, `upd_pp` is {0, current privilege bit 0}. The target level's enable bit is to be cleared by the consumer.
- R3: `upd_cause` holds the final cause code zero-extended, with bit 31 set for interrupts and clear for exceptions. `upd_epc` holds `cur_pc` from the request cycle.
- R4: `upd_pc` is the selected vector register (`stvec_in` for supervisor, `mtvec_in` for machine) with bits 1:0 cleared. When that register's bits 1:0 equal 1 and the trap is an interrupt, 4 times the cause code is added.
- R5: `upd_tval` equals `trap_addr` for exception codes 0, 1, 4, 5, 6, 7, 12, 13 and 15 (misaligned, access fault and page fault for fetch, load and store). It is 0 for every other exception code and for all interrupts.
- R6: An exception request with raw cause 8, 9 or 11 is an environment call. It is recoded by current privilege: 8 from U, 9 from S, 11 from M or the reserved level. The recoded value is used for delegation and for the cause word.
- R7: `resv_set` makes `resv_valid` 1 from the next cycle. A cycle in which `cur_priv` differs from its value in the previous cycle clears it. A trap whose target privilege differs from `cur_priv` also clears it. Clearing wins over setting. A trap to the same level keeps the reservation.
- R8: `upd_valid` is a one-cycle pulse in the cycle after each `trap_valid` pulse. While `rst_n` is low, requests are ignored and `upd_valid` and `resv_valid` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_valid | input | 1 | One-cycle trap request |
| trap_async | input | 1 | 1 = interrupt, 0 = exception |
| trap_cause | input | 5 | Raw cause code |
| trap_addr | input | 32 | Faulting address |
| cur_pc | input | 32 | Pc of the trapping instruction |
| cur_priv | input | 2 | Current privilege level |
| cur_sie | input | 1 | Current supervisor interrupt enable |
| cur_mie | input | 1 | Current machine interrupt enable |
| deleg_exc | input | 32 | Exception delegation mask |
| deleg_int | input | 32 | Interrupt delegation mask |
| stvec_in | input | 32 | Supervisor vector base and mode |
| mtvec_in | input | 32 | Machine vector base and mode |
| resv_set | input | 1 | Load-reserved executed |
| upd_valid | output | 1 | Update record valid |
| upd_to_s | output | 1 | Target is supervisor |
| upd_priv | output | 2 | New privilege |
| upd_pc | output | 32 | New fetch address |
| upd_cause | output | 32 | Cause word |
| upd_epc | output | 32 | Saved pc |
| upd_tval | output | 32 | Trap value |
| upd_pie | output | 1 | Saved previous enable |
| upd_pp | output | 2 | Saved previous privilege |
| resv_valid | output | 1 | Load reservation held |

## Verification
A wrong routing decision shows in the first update record after the request. It moves `upd_priv`, `upd_to_s` and `upd_pc` together, so one cycle after `trap_valid` the vector base visibly belongs to the wrong level. A wrong ecall recode or a wrong tval qualification shows as a mismatching cause or tval word in that same record. A stale reservation state survives silently until the bench observes `resv_valid`, which it does after every cycle. A missed clear is therefore caught one cycle after the privilege change that should have removed it.

// File: rtl/trap_entry_pkg.sv
// Shared privilege encoding and cause codes for the trap entry unit.
// Assumes a 32-bit machine word and 5-bit cause codes.
package trap_entry_pkg;
    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam logic [4:0] EC_FETCH_MISALIGN = 5'd0;
    localparam logic [4:0] EC_FETCH_ACCESS   = 5'd1;
    localparam logic [4:0] EC_LOAD_MISALIGN  = 5'd4;
    localparam logic [4:0] EC_LOAD_ACCESS    = 5'd5;
    localparam logic [4:0] EC_STORE_MISALIGN = 5'd6;
    localparam logic [4:0] EC_STORE_ACCESS   = 5'd7;
    localparam logic [4:0] EC_CALL_FROM_U    = 5'd8;
    localparam logic [4:0] EC_CALL_FROM_S    = 5'd9;
    localparam logic [4:0] EC_CALL_FROM_M    = 5'd11;
    localparam logic [4:0] EC_FETCH_PAGE     = 5'd12;
    localparam logic [4:0] EC_LOAD_PAGE      = 5'd13;
    localparam logic [4:0] EC_STORE_PAGE     = 5'd15;

    // True for exception codes that report a faulting address.
    function automatic logic code_has_addr(input logic [4:0] code);
        case (code)
            EC_FETCH_MISALIGN, EC_FETCH_ACCESS, EC_LOAD_MISALIGN,
            EC_LOAD_ACCESS, EC_STORE_MISALIGN, EC_STORE_ACCESS,
            EC_FETCH_PAGE, EC_LOAD_PAGE, EC_STORE_PAGE: code_has_addr = 1'b1;
            default: code_has_addr = 1'b0;
        endcase
    endfunction

    // True for any raw code that denotes an environment call.
    function automatic logic code_is_call(input logic [4:0] code);
        code_is_call = (code == EC_CALL_FROM_U) || (code == EC_CALL_FROM_S) ||
                       (code == EC_CALL_FROM_M);
    endfunction
endpackage

// File: rtl/trap_route.sv
// Recodes environment calls by privilege and decides the target level.
// Assumes privilege encoding U=0, S=1, M=3; level 2 behaves like M.
module trap_route
    import trap_entry_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 5
) (
    input  logic               is_async,
    input  logic [CAUSE_W-1:0] raw_cause,
    input  logic [1:0]         priv,
    input  logic [XLEN-1:0]    exc_mask,
    input  logic [XLEN-1:0]    int_mask,
    output logic [CAUSE_W-1:0] final_cause,
    output logic               go_super
);
    logic [XLEN-1:0] mask_sel;
    logic            low_level;

    // Rewrite an environment call so its code names the calling level.
    always_comb begin
        final_cause = raw_cause;
        if (!is_async && code_is_call(raw_cause)) begin
            case (priv)
                PRIV_U:  final_cause = EC_CALL_FROM_U;
                PRIV_S:  final_cause = EC_CALL_FROM_S;
                default: final_cause = EC_CALL_FROM_M;
            endcase
        end
    end

    // Pick the mask by trap kind and route to supervisor when allowed.
    always_comb begin
        mask_sel  = is_async ? int_mask : exc_mask;
        low_level = (priv == PRIV_U) || (priv == PRIV_S);
        go_super  = low_level && mask_sel[final_cause];
    end
endmodule

// File: rtl/trap_target.sv
// Computes the new fetch address and the trap value for one trap.
// Assumes vector mode lives in bits 1:0 of the vector register.
module trap_target
    import trap_entry_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 5
) (
    input  logic               is_async,
    input  logic [CAUSE_W-1:0] code,
    input  logic               go_super,
    input  logic [XLEN-1:0]    svec,
    input  logic [XLEN-1:0]    mvec,
    input  logic [XLEN-1:0]    fault_addr,
    output logic [XLEN-1:0]    next_pc,
    output logic [XLEN-1:0]    tval
);
    localparam logic [1:0] MODE_VECTORED = 2'd1;

    logic [XLEN-1:0] vec_sel;
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    // Align the selected base and add the per-cause slot for interrupts.
    always_comb begin
        vec_sel = go_super ? svec : mvec;
        base    = {vec_sel[XLEN-1:2], 2'b00};
        offset  = '0;
        if (is_async && (vec_sel[1:0] == MODE_VECTORED))
            offset = {{(XLEN-CAUSE_W-2){1'b0}}, code, 2'b00};
        next_pc = base + offset;
    end

    // Report the address only for address-carrying exceptions.
    always_comb begin
        tval = (!is_async && code_has_addr(code)) ? fault_addr : '0;
    end
endmodule

// File: rtl/trap_resv.sv
// Holds the load-reservation flag and drops it on any privilege change.
// Assumes the privilege input is stable between clock edges.
module trap_resv
    import trap_entry_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] priv_in,
    input  logic       trap_fire,
    input  logic [1:0] trap_priv,
    input  logic       set_req,
    output logic       resv_valid
);
    logic [1:0] prev_priv_q;
    logic       resv_q;
    logic       drop;

    // A change seen on the input or caused by this trap removes the flag.
    always_comb begin
        drop = (priv_in != prev_priv_q) || (trap_fire && (trap_priv != priv_in));
    end

    // Track last privilege and update the reservation, clear over set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_priv_q <= PRIV_M;
            resv_q      <= 1'b0;
        end else begin
            prev_priv_q <= priv_in;
            if (drop)
                resv_q <= 1'b0;
            else if (set_req)
                resv_q <= 1'b1;
        end
    end

    assign resv_valid = resv_q;

    assert_resv_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_in != $past(priv_in)) |=> !resv_valid);
    assert_resv_trap_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_fire && (trap_priv != priv_in)) |=> !resv_valid);
endmodule

// File: rtl/trap_entry_unit.sv
// Trap entry unit: registers a full state-update record one cycle after a
// trap request and keeps the load reservation. Assumes a 32-bit word,
// single-cycle request pulses and a synchronous active-low reset.
module trap_entry_unit
    import trap_entry_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_valid,
    input  logic               trap_async,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic [XLEN-1:0]    trap_addr,
    input  logic [XLEN-1:0]    cur_pc,
    input  logic [1:0]         cur_priv,
    input  logic               cur_sie,
    input  logic               cur_mie,
    input  logic [XLEN-1:0]    deleg_exc,
    input  logic [XLEN-1:0]    deleg_int,
    input  logic [XLEN-1:0]    stvec_in,
    input  logic [XLEN-1:0]    mtvec_in,
    input  logic               resv_set,
    output logic               upd_valid,
    output logic               upd_to_s,
    output logic [1:0]         upd_priv,
    output logic [XLEN-1:0]    upd_pc,
    output logic [XLEN-1:0]    upd_cause,
    output logic [XLEN-1:0]    upd_epc,
    output logic [XLEN-1:0]    upd_tval,
    output logic               upd_pie,
    output logic [1:0]         upd_pp,
    output logic               resv_valid
);
    localparam int CAUSE_PAD = XLEN - 1 - CAUSE_W;

    logic [CAUSE_W-1:0] code_w;
    logic               to_s_w;
    logic [XLEN-1:0]    pc_w;
    logic [XLEN-1:0]    tval_w;
    logic [1:0]         tgt_priv_w;

    trap_route #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) route_i (
        .is_async   (trap_async),
        .raw_cause  (trap_cause),
        .priv       (cur_priv),
        .exc_mask   (deleg_exc),
        .int_mask   (deleg_int),
        .final_cause(code_w),
        .go_super   (to_s_w)
    );

    trap_target #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) target_i (
        .is_async  (trap_async),
        .code      (code_w),
        .go_super  (to_s_w),
        .svec      (stvec_in),
        .mvec      (mtvec_in),
        .fault_addr(trap_addr),
        .next_pc   (pc_w),
        .tval      (tval_w)
    );

    // Target privilege follows the routing decision.
    always_comb begin
        tgt_priv_w = to_s_w ? PRIV_S : PRIV_M;
    end

    trap_resv resv_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .priv_in   (cur_priv),
        .trap_fire (trap_valid),
        .trap_priv (tgt_priv_w),
        .set_req   (resv_set),
        .resv_valid(resv_valid)
    );

    // Capture the update record on a request; pulse valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_valid <= 1'b0;
            upd_to_s  <= 1'b0;
            upd_priv  <= PRIV_M;
            upd_pc    <= '0;
            upd_cause <= '0;
            upd_epc   <= '0;
            upd_tval  <= '0;
            upd_pie   <= 1'b0;
            upd_pp    <= 2'd0;
        end else begin
            upd_valid <= trap_valid;
            if (trap_valid) begin
                upd_to_s  <= to_s_w;
                upd_priv  <= tgt_priv_w;
                upd_pc    <= pc_w;
                upd_cause <= {trap_async, {CAUSE_PAD{1'b0}}, code_w};
                upd_epc   <= cur_pc;
                upd_tval  <= tval_w;
                upd_pie   <= to_s_w ? cur_sie : cur_mie;
                upd_pp    <= to_s_w ? {1'b0, cur_priv[0]} : cur_priv;
            end
        end
    end

    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> $past(trap_valid));
    assert_epc_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (upd_epc == $past(cur_pc)));
    assert_cause_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (upd_cause[XLEN-1] == $past(trap_async)));
    assert_no_s_from_m_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_to_s) |-> ($past(cur_priv) != PRIV_M));
    assert_tval_int_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_cause[XLEN-1]) |-> (upd_tval == '0));
    assert_pc_exc_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_cause[XLEN-1]) |-> (upd_pc[1:0] == 2'b00));
endmodule

// File: tb/trap_entry_unit_tb_top.sv
module trap_entry_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_valid = 1'b0;
    logic        trap_async = 1'b0;
    logic [4:0]  trap_cause = '0;
    logic [31:0] trap_addr = '0;
    logic [31:0] cur_pc = '0;
    logic [1:0]  cur_priv = 2'd3;
    logic        cur_sie = 1'b0;
    logic        cur_mie = 1'b0;
    logic [31:0] deleg_exc = '0;
    logic [31:0] deleg_int = '0;
    logic [31:0] stvec_in = '0;
    logic [31:0] mtvec_in = '0;
    logic        resv_set = 1'b0;
    logic        upd_valid, upd_to_s, upd_pie, resv_valid;
    logic [1:0]  upd_priv, upd_pp;
    logic [31:0] upd_pc, upd_cause, upd_epc, upd_tval;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic       m_resv = 1'b0;
    logic [1:0] m_prev = 2'd3;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_entry_unit dut_i (
        .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_async(trap_async),
        .trap_cause(trap_cause), .trap_addr(trap_addr), .cur_pc(cur_pc),
        .cur_priv(cur_priv), .cur_sie(cur_sie), .cur_mie(cur_mie),
        .deleg_exc(deleg_exc), .deleg_int(deleg_int), .stvec_in(stvec_in),
        .mtvec_in(mtvec_in), .resv_set(resv_set), .upd_valid(upd_valid),
        .upd_to_s(upd_to_s), .upd_priv(upd_priv), .upd_pc(upd_pc),
        .upd_cause(upd_cause), .upd_epc(upd_epc), .upd_tval(upd_tval),
        .upd_pie(upd_pie), .upd_pp(upd_pp), .resv_valid(resv_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // R6 model: final code.
    function automatic logic [4:0] f_code(input logic a, input logic [4:0] c, input logic [1:0] p);
        if (!a && (c == 5'd8 || c == 5'd9 || c == 5'd11))
            return (p == 2'd0) ? 5'd8 : (p == 2'd1) ? 5'd9 : 5'd11;
        return c;
    endfunction

    // R1 model: supervisor routing.
    function automatic logic f_to_s(input logic a, input logic [4:0] code, input logic [1:0] p,
                                    input logic [31:0] me, input logic [31:0] mi);
        logic [31:0] m;
        m = a ? mi : me;
        return (p <= 2'd1) && m[code];
    endfunction

    // R4 model: new pc.
    function automatic logic [31:0] f_pc(input logic a, input logic [4:0] code, input logic [31:0] v);
        logic [31:0] b;
        b = v & ~32'h3;
        if (a && v[1:0] == 2'd1) b = b + ({27'd0, code} << 2);
        return b;
    endfunction

    // R5 model: trap value.
    function automatic logic [31:0] f_tval(input logic a, input logic [4:0] code, input logic [31:0] ad);
        if (a) return 32'd0;
        case (code)
            5'd0, 5'd1, 5'd4, 5'd5, 5'd6, 5'd7, 5'd12, 5'd13, 5'd15: return ad;
            default: return 32'd0;
        endcase
    endfunction

    // One clock: inputs already set; model edge, then check after it.
    task automatic tick();
        logic [4:0]  code;
        logic        s;
        logic [1:0]  tp;
        logic        tv;
        logic        drop;
        code = f_code(trap_async, trap_cause, cur_priv);
        s    = f_to_s(trap_async, code, cur_priv, deleg_exc, deleg_int);
        tp   = s ? 2'd1 : 2'd3;
        tv   = trap_valid;
        drop = (cur_priv != m_prev) || (tv && tp != cur_priv);
        if (drop) m_resv = 1'b0;
        else if (resv_set) m_resv = 1'b1;
        m_prev = cur_priv;
        @(posedge clk);
        @(negedge clk);
        check("R8 valid pulse", {31'd0, upd_valid}, {31'd0, tv});
        check("R7 reservation", {31'd0, resv_valid}, {31'd0, m_resv});
        if (tv) begin
            check("R1 target", {31'd0, upd_to_s}, {31'd0, s});
            check("R1 new priv", {30'd0, upd_priv}, {30'd0, tp});
            check("R3 R6 cause", upd_cause, {trap_async, 26'd0, code});
            check("R3 epc", upd_epc, cur_pc);
            check("R4 new pc", upd_pc, f_pc(trap_async, code, s ? stvec_in : mtvec_in));
            check("R5 tval", upd_tval, f_tval(trap_async, code, trap_addr));
            check("R2 pie", {31'd0, upd_pie}, {31'd0, s ? cur_sie : cur_mie});
            check("R2 pp", {30'd0, upd_pp}, {30'd0, s ? {1'b0, cur_priv[0]} : cur_priv});
        end
        trap_valid = 1'b0;
        resv_set   = 1'b0;
    endtask

    task automatic trap(input logic a, input logic [4:0] c, input logic [1:0] p);
        trap_async = a; trap_cause = c; cur_priv = p; trap_valid = 1'b1;
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R8: request during reset is ignored.
        @(negedge clk);
        trap_valid = 1'b1; resv_set = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R8 reset valid", {31'd0, upd_valid}, 32'd0);
        check("R8 reset resv", {31'd0, resv_valid}, 32'd0);
        trap_valid = 1'b0; resv_set = 1'b0;
        rst_n = 1'b1;
        cur_priv = 2'd3; m_prev = 2'd3; m_resv = 1'b0;
        tick();

        // R6: ecall recode from each level, all raw call codes.
        deleg_exc = 32'h0; mtvec_in = 32'h0000_1000; stvec_in = 32'h0000_2000;
        cur_pc = 32'h0000_0400;
        trap(1'b0, 5'd11, 2'd0);
        trap(1'b0, 5'd8, 2'd1);
        trap(1'b0, 5'd9, 2'd3);
        // R1: delegated bit set but from M stays in machine.
        deleg_exc = 32'hFFFF_FFFF;
        trap(1'b0, 5'd13, 2'd3);
        // R1: delegated from U and S.
        trap(1'b0, 5'd13, 2'd0);
        trap(1'b0, 5'd8, 2'd1);
        // R4: vectored interrupt adds 4*cause; vectored exception does not.
        mtvec_in = 32'h0000_8001; deleg_int = 32'h0;
        trap_addr = 32'hDEAD_BEEF;
        trap(1'b1, 5'd7, 2'd3);
        trap(1'b0, 5'd5, 2'd3);
        stvec_in = 32'h0000_4001; deleg_int = 32'h0000_0020;
        trap(1'b1, 5'd5, 2'd1);
        // R5: non-address exception gives zero tval.
        trap(1'b0, 5'd2, 2'd3);
        // R7: set, trap M->M keeps, trap to other level drops.
        cur_priv = 2'd3; resv_set = 1'b1; tick();
        deleg_exc = 32'h0;
        trap(1'b0, 5'd2, 2'd3);
        cur_priv = 2'd1; tick();
        resv_set = 1'b1; tick();
        trap(1'b0, 5'd2, 2'd1);
        cur_priv = 2'd3; tick();
        resv_set = 1'b1; tick();
        cur_priv = 2'd0; tick();

        // Random mix.
        for (int i = 0; i < 400; i++) begin
            trap_async = $urandom_range(0, 1);
            trap_cause = 5'($urandom_range(0, 15));
            trap_addr  = $urandom();
            cur_pc     = $urandom();
            case ($urandom_range(0, 3))
                0: cur_priv = 2'd0;
                1: cur_priv = 2'd1;
                2: cur_priv = 2'd3;
                default: cur_priv = 2'd2;
            endcase
            cur_sie   = 1'($urandom_range(0, 1));
            cur_mie   = 1'($urandom_range(0, 1));
            deleg_exc = $urandom();
            deleg_int = $urandom();
            stvec_in  = $urandom();
            mtvec_in  = $urandom();
            resv_set  = 1'($urandom_range(0, 1));
            trap_valid = ($urandom_range(0, 2) != 0);
            tick();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule